// File: doc/BRIEF.md
# Add/Subtract Unit with Registered Condition Flags

This block adds or subtracts two integer operands and returns the result in the same cycle. It can also update four registered condition flags from that operation: negative (N), zero (Z), carry (C) and overflow (V). An add folds a carry input into the sum, so wide additions can be chained across several operations. A subtract is formed as the first operand plus the bit-inverse of the second with a forced carry of one. For a subtract, C = 1 means that no borrow occurred, and the carry input is not used.

Flag updates are chosen per operation with a set-flags input. When that input is low, the result is still produced but the flags keep their values. When it is high, all four flags load on the rising clock edge on which the operation is presented.

C and V are not found from bit tricks. The low WIDTH bits of the result are compared with the full unsigned sum and with the full signed sum. A mismatch with the unsigned sum sets C, and a mismatch with the signed sum sets V. The result path is purely combinational. The only state is the flag register.

Top module: `asu_core`

## Requirements
- R1: With op_sub = 0, result equals (op_a + op_b + carry_in) modulo 2^WIDTH, in the same cycle.
- R2: With op_sub = 1, result equals (op_a - op_b) modulo 2^WIDTH in the same cycle, and carry_in has no effect on result or on any flag.
- R3: On a clock edge where set_flags is 0, flag_n, flag_z, flag_c and flag_v keep their previous values, whatever the operands and operation are.
- R4: On a clock edge where set_flags is 1, all four flags load from the operation presented in that cycle. flag_n becomes bit WIDTH-1 of result, and flag_z becomes 1 exactly when result is zero.
- R5: For an add, the loaded flag_c is 1 exactly when op_a + op_b + carry_in, taken as unsigned integers, exceeds 2^WIDTH - 1. For a subtract, it is 1 exactly when op_a >= op_b as unsigned values (no borrow).
- R6: The loaded flag_v is 1 exactly when the two's-complement sum (op_a + op_b + carry_in) or difference (op_a - op_b) falls outside the range -2^(WIDTH-1) to 2^(WIDTH-1) - 1.
- R7: While rst_n is 0, all four flags are 0 without waiting for a clock edge. They remain 0 until a flag-setting operation is clocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags load on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| carry_in | input | 1 | Carry input used by add only |
| set_flags | input | 1 | 1 = load flags from this operation |
| result | output | WIDTH | Sum or difference, combinational |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry / not-borrow flag |
| flag_v | output | 1 | Registered signed overflow flag |

## Verification
The bench builds the unit with WIDTH = 4. This puts every pair of operands, both carry inputs and both operations in reach: 1024 cases, each checked for its result and all four flags. At that width every signed and unsigned wrap is hit, including the most negative value minus one and all-ones plus carry. A second sweep with set_flags low confirms that the flags hold across every operation.

// File: rtl/asu_pkg.sv
package asu_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } asu_flags_t;
endpackage

// File: rtl/asu_sum.sv
// Adder datapath: subtract folds into add through operand inversion.
module asu_sum #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  localparam int UW = WIDTH + 1;
  localparam int SW = WIDTH + 2;

  logic [WIDTH-1:0] b_eff;
  logic             cin_eff;
  logic [UW-1:0]    usum;
  logic [SW-1:0]    ssum;
  logic [SW-1:0]    trunc_sext;

  always_comb begin
    b_eff   = sub ? ~b : b;
    cin_eff = sub ? 1'b1 : cin;
    usum    = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin_eff};
    ssum    = {{2{a[WIDTH-1]}}, a} + {{2{b_eff[WIDTH-1]}}, b_eff}
            + {{(WIDTH+1){1'b0}}, cin_eff};
    sum        = usum[WIDTH-1:0];
    trunc_sext = {{2{usum[WIDTH-1]}}, usum[WIDTH-1:0]};
    // Carry: truncated value differs from the full unsigned sum.
    cout = ({1'b0, usum[WIDTH-1:0]} != usum);
    // Overflow: sign-extended truncated value differs from the full signed sum.
    ovf  = (trunc_sext != ssum);
  end
endmodule

// File: rtl/asu_flag_gen.sv
module asu_flag_gen #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]       sum,
  input  logic                   cout,
  input  logic                   ovf,
  output asu_pkg::asu_flags_t    flags
);
  always_comb begin
    flags.n = sum[WIDTH-1];
    flags.z = (sum == '0);
    flags.c = cout;
    flags.v = ovf;
  end
endmodule

// File: rtl/asu_flag_reg.sv
module asu_flag_reg (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  asu_pkg::asu_flags_t d,
  output asu_pkg::asu_flags_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/asu_core.sv
module asu_core #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             op_sub,
  input  logic             carry_in,
  input  logic             set_flags,
  output logic [WIDTH-1:0] result,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v
);
  import asu_pkg::*;

  logic       cout;
  logic       ovf;
  asu_flags_t next_flags;
  asu_flags_t cur_flags;

  asu_sum #(.WIDTH(WIDTH)) u_sum (
    .a(op_a), .b(op_b), .sub(op_sub), .cin(carry_in),
    .sum(result), .cout(cout), .ovf(ovf)
  );

  asu_flag_gen #(.WIDTH(WIDTH)) u_gen (
    .sum(result), .cout(cout), .ovf(ovf), .flags(next_flags)
  );

  asu_flag_reg u_reg (
    .clk(clk), .rst_n(rst_n), .load(set_flags),
    .d(next_flags), .q(cur_flags)
  );

  assign flag_n = cur_flags.n;
  assign flag_z = cur_flags.z;
  assign flag_c = cur_flags.c;
  assign flag_v = cur_flags.v;
endmodule

// File: rtl/asu_core_chk.sv
module asu_core_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             op_sub,
  input logic             carry_in,
  input logic             set_flags,
  input logic [WIDTH-1:0] result,
  input logic             flag_n,
  input logic             flag_z,
  input logic             flag_c,
  input logic             flag_v
);
  logic [3:0] fl;
  assign fl = {flag_n, flag_z, flag_c, flag_v};

  p_add_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !op_sub |-> result == WIDTH'(op_a + op_b + {{(WIDTH-1){1'b0}}, carry_in}));

  p_sub_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_sub |-> result == WIDTH'(op_a - op_b));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !set_flags |=> $stable(fl));

  p_neg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_flags |=> flag_n == $past(result[WIDTH-1]));

  p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_flags |=> flag_z == ($past(result) == '0));

  p_borrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && op_sub) |=> flag_c == $past(op_a >= op_b));

  always @(posedge clk) begin
    if (!rst_n) p_reset_r7: assert (fl == 4'b0000);
  end
endmodule

bind asu_core asu_core_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sub(op_sub),
  .carry_in(carry_in), .set_flags(set_flags), .result(result),
  .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
);

// File: tb/sim_asu_core.sv
module sim_asu_core;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic         op_sub = 1'b0, carry_in = 1'b0, set_flags = 1'b0;
  logic [W-1:0] result;
  logic         flag_n, flag_z, flag_c, flag_v;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  asu_core #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sub(op_sub),
    .carry_in(carry_in), .set_flags(set_flags), .result(result),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (a=%0d b=%0d sub=%0d cin=%0d)",
               req, act, exp, op_a, op_b, op_sub, carry_in);
    end
  endtask

  function automatic int sgn(input int v);
    return (v >= M/2) ? v - M : v;
  endfunction

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hold_flags;
    // R7: reset state
    #1;
    chk("R7 reset", {flag_n, flag_z, flag_c, flag_v}, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 after release", {flag_n, flag_z, flag_c, flag_v}, 0);

    // Exhaustive sweep with flag loading
    for (int s = 0; s < 2; s++)
      for (int ci = 0; ci < 2; ci++)
        for (int a = 0; a < M; a++)
          for (int b = 0; b < M; b++) begin
            int ures, eres, ssum, en, ez, ec, ev;
            op_a = a[W-1:0]; op_b = b[W-1:0];
            op_sub = s[0]; carry_in = ci[0]; set_flags = 1'b1;
            if (s == 0) begin
              ures = a + b + ci;
              ssum = sgn(a) + sgn(b) + ci;
              ec   = (ures > M - 1) ? 1 : 0;
            end else begin
              ures = a - b + M;
              ssum = sgn(a) - sgn(b);
              ec   = (a >= b) ? 1 : 0;
            end
            eres = ures % M;
            en = (eres >= M/2) ? 1 : 0;
            ez = (eres == 0) ? 1 : 0;
            ev = (ssum < -(M/2) || ssum > M/2 - 1) ? 1 : 0;
            #1;
            chk(s == 0 ? "R1 add result" : "R2 sub result", result, eres);
            @(posedge clk); #1;
            chk("R4 flag_n", flag_n, en);
            chk("R4 flag_z", flag_z, ez);
            chk("R5 flag_c", flag_c, ec);
            chk("R6 flag_v", flag_v, ev);
            @(negedge clk);
          end

    // R3: flags hold when set_flags is low, across every operation
    hold_flags = {flag_n, flag_z, flag_c, flag_v};
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < M; a++)
        for (int b = 0; b < M; b++) begin
          op_a = a[W-1:0]; op_b = b[W-1:0];
          op_sub = s[0]; carry_in = ~carry_in; set_flags = 1'b0;
          @(posedge clk); #1;
          chk("R3 hold", {flag_n, flag_z, flag_c, flag_v}, hold_flags);
          @(negedge clk);
        end

    // Load a known nonzero flag set, then check asynchronous reset (R7)
    op_a = 4'h7; op_b = 4'h1; op_sub = 1'b0; carry_in = 1'b0; set_flags = 1'b1;
    @(posedge clk); #1;
    chk("R6 max+1 flags", {flag_n, flag_z, flag_c, flag_v}, 4'b1001);
    @(negedge clk);
    set_flags = 1'b0;
    #0.5 rst_n = 1'b0;
    #0.5;
    chk("R7 async reset", {flag_n, flag_z, flag_c, flag_v}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R7 stays zero", {flag_n, flag_z, flag_c, flag_v}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule